// File: doc/BRIEF.md
# Prioritized Special-Event Vector Dispatcher

This block decides when a processor may leave its normal instruction flow to handle a special event, and it supplies the handler address for that event. Four event classes compete: a reset request, an exception request, a non-maskable interrupt and a bank of maskable interrupt sources. Reset is acted on in whatever cycle it appears. Every other class is accepted only in a cycle in which the core reports a taken interruptible jump. The same rule applies while a handler is already running, so a handler can itself be interrupted at one of its own taken interruptible jumps.

The maskable sources share a pending register. A source's pending bit is set by its input line or by a software write, and it is cleared by a software write or when the block takes that source. The non-maskable line drives the pending bit of one reserved source index, and that bit bypasses the mask. Each source has a programmable priority level and a programmable handler vector. All exceptions share a single programmable vector, and reset always goes to a fixed base address. A small word-addressed register port gives software access to these registers.

The decision is registered. An event sampled at a rising edge shows up as a one-cycle `take_evt` strobe after that edge, together with the event class, the target address and the source index.

Top module: `sev_dispatch`

## Requirements
- R1: When `rst_req` is 1 at an edge, the next cycle shows `take_evt`=1 with class code 0 and target `DRAM_BASE`, whatever the other inputs are. A reset take clears no pending bit.
- R2: When `rst_req` is 0 and `int_jump_taken` is 0 at an edge, `take_evt` is 0 in the next cycle and pending bits are only added or cleared by lines and software writes.
- R3: At a taken jump the classes rank exception (code 1) above non-maskable (code 2) above maskable (code 3). Only the winner is taken.
- R4: An exception take targets the exception vector register at word address 8 and reports source index 0.
- R5: A pending bit is set by its line being 1 at an edge or by writing a 1 to that bit of the set register at word address 0. Word address 1 reads the pending register.
- R6: Writing a 1 to a bit of the clear register at word address 2 clears that pending bit. Zero bits of the write change nothing. A set in the same cycle wins over a clear.
- R7: A maskable source is eligible only when its pending bit and its bit in the mask register (word address 3) are both 1. Source `NMI_IDX` (default 0) is set by `nmi_line` as well as by its own line, ignores the mask, and is taken with class code 2.
- R8: Among eligible maskable sources the one with the highest 4-bit level wins, and the lower index wins a tie. Levels sit in four words at addresses 4 to 7; word w holds sources 8w to 8w+7, with source 8w+j in bits 4j+3 to 4j.
- R9: An interrupt take targets the vector register of the chosen source (word address 32+index) and reports that index on `evt_id`.
- R10: Taking a non-maskable or maskable source clears its pending bit at the same edge, unless its line is still 1.
- R11: While `rst_n` is 0 and right after it is released, `take_evt` is 0 and every readable register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| rst_req | input | 1 | Reset event request |
| exc_req | input | 1 | Exception request |
| nmi_line | input | 1 | Non-maskable interrupt line |
| irq_lines | input | 32 | Maskable interrupt source lines |
| int_jump_taken | input | 1 | Pulse: an interruptible jump was taken this cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| take_evt | output | 1 | Event taken strobe |
| evt_kind | output | 2 | Event class: 0 reset, 1 exception, 2 non-maskable, 3 maskable |
| evt_target | output | 32 | Handler address |
| evt_id | output | 5 | Source index of the taken interrupt |

## Verification
The bench aims at cycles where several classes arrive together. A design with the ranking wrong would vector an exception to an interrupt vector, or let a reset wait for a jump. It also targets equal priority levels, where the wrong tie-break picks the higher index, and masked pending sources, which a faulty mask would take at the next jump. A clear written with zero bits, and a set and a clear landing in the same cycle, catch a pending register that clears too much. Checking the pending register after each take shows whether the taken bit stays stuck, which would make the design take the same source again.

// File: rtl/sev_pkg.sv
package sev_pkg;
  typedef enum logic [1:0] {
    EV_RST = 2'd0,
    EV_EXC = 2'd1,
    EV_NMI = 2'd2,
    EV_INT = 2'd3
  } ev_kind_t;

  localparam int A_SET  = 0;
  localparam int A_PEND = 1;
  localparam int A_CLR  = 2;
  localparam int A_MASK = 3;
  localparam int A_LVL0 = 4;
  localparam int A_EXCV = 8;
  localparam int A_VEC0 = 32;
endpackage

// File: rtl/sev_pend_bank.sv
module sev_pend_bank
  import sev_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int LVL_W   = 4,
  parameter int NMI_IDX = 0,
  parameter int CW      = 6,
  parameter int DW      = 32,
  localparam int IW     = $clog2(NSRC),
  localparam int NLW    = (NSRC * LVL_W) / DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        irq_lines,
  input  logic                   nmi_line,
  input  logic                   cfg_we,
  input  logic [CW-1:0]          cfg_addr,
  input  logic [DW-1:0]          cfg_wdata,
  input  logic                   take_clr,
  input  logic [IW-1:0]          take_idx,
  output logic [NSRC-1:0]        pend_q,
  output logic [NSRC-1:0]        mask_q,
  output logic [NLW*DW-1:0]      lvl_q
);
  logic [NSRC-1:0] sw_set, sw_clr, ev_clr, set_now, clr_now;
  logic [DW-1:0]   lvl_words [NLW];

  always_comb begin
    sw_set  = (cfg_we && cfg_addr == CW'(A_SET)) ? cfg_wdata[NSRC-1:0] : '0;
    sw_clr  = (cfg_we && cfg_addr == CW'(A_CLR)) ? cfg_wdata[NSRC-1:0] : '0;
    ev_clr  = take_clr ? (NSRC'(1) << take_idx) : '0;
    set_now = irq_lines | sw_set | (nmi_line ? (NSRC'(1) << NMI_IDX) : '0);
    clr_now = sw_clr | ev_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      for (int w = 0; w < NLW; w++) lvl_words[w] <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_now) | set_now;
      if (cfg_we && cfg_addr == CW'(A_MASK)) mask_q <= cfg_wdata[NSRC-1:0];
      for (int w = 0; w < NLW; w++)
        if (cfg_we && cfg_addr == CW'(A_LVL0 + w)) lvl_words[w] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < NLW; g++) begin : g_flat
    assign lvl_q[g*DW +: DW] = lvl_words[g];
  end

  // R10: the taken source is gone next cycle unless something set it again
  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_clr && !irq_lines[take_idx] && !(nmi_line && take_idx == IW'(NMI_IDX))
     && !(cfg_we && cfg_addr == CW'(A_SET)))
    |=> !pend_q[$past(take_idx)]);

  // R6: a clear write never drops a bit whose write-data bit was zero
  p_zero_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CW'(A_CLR) && !take_clr)
    |=> ((($past(pend_q) & ~$past(cfg_wdata[NSRC-1:0])) & ~pend_q) == '0));

  // R5: a line seen at an edge leaves its pending bit set
  p_line_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines != '0) |=> ((pend_q & $past(irq_lines)) == $past(irq_lines)));
endmodule

// File: rtl/sev_arbiter.sv
module sev_arbiter #(
  parameter int NSRC    = 32,
  parameter int LVL_W   = 4,
  parameter int NMI_IDX = 0,
  localparam int IW     = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC-1:0]       mask,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  output logic                  nmi_hit,
  output logic                  irq_hit,
  output logic [IW-1:0]         irq_idx
);
  logic [NSRC-1:0]  elig;
  logic [LVL_W-1:0] best;

  function automatic logic [LVL_W-1:0] lvl_at(input logic [NSRC*LVL_W-1:0] f, input int i);
    return f[i*LVL_W +: LVL_W];
  endfunction

  assign nmi_hit = pend[NMI_IDX];
  assign elig    = pend & mask & ~(NSRC'(1) << NMI_IDX);

  // scan from the top index down; ">=" lets the lower index win a tie
  always_comb begin
    irq_hit = 1'b0;
    irq_idx = '0;
    best    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!irq_hit || lvl_at(lvl_flat, i) >= best)) begin
        irq_hit = 1'b1;
        irq_idx = IW'(i);
        best    = lvl_at(lvl_flat, i);
      end
    end
  end

  always_comb begin
    if (irq_hit) begin
      p_grant_unmasked_r7: assert (pend[irq_idx] && mask[irq_idx] && irq_idx != IW'(NMI_IDX));
      for (int j = 0; j < NSRC; j++) begin
        if (pend[j] && mask[j] && j != NMI_IDX)
          p_no_better_r8: assert (lvl_at(lvl_flat, j) < lvl_at(lvl_flat, int'(irq_idx)) ||
                                  (lvl_at(lvl_flat, j) == lvl_at(lvl_flat, int'(irq_idx)) &&
                                   j >= int'(irq_idx)));
      end
    end
  end
endmodule

// File: rtl/sev_vec_file.sv
module sev_vec_file
  import sev_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int CW   = 6,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [IW-1:0] sel_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] sel_vec,
  output logic [DW-1:0] rd_vec,
  output logic [DW-1:0] exc_q
);
  logic [DW-1:0] vec_q [NSRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q <= '0;
      for (int i = 0; i < NSRC; i++) vec_q[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CW'(A_EXCV)) exc_q <= cfg_wdata;
      for (int i = 0; i < NSRC; i++)
        if (cfg_addr == CW'(A_VEC0 + i)) vec_q[i] <= cfg_wdata;
    end
  end

  assign sel_vec = vec_q[sel_idx];
  assign rd_vec  = vec_q[rd_idx];

  // R4: the exception vector only moves on a write to its own address
  p_excv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == CW'(A_EXCV)) |=> $stable(exc_q));
endmodule

// File: rtl/sev_dispatch.sv
module sev_dispatch
  import sev_pkg::*;
#(
  parameter int          NSRC      = 32,
  parameter int          LVL_W     = 4,
  parameter int          NMI_IDX   = 0,
  parameter int          CW        = 6,
  parameter int          DW        = 32,
  parameter logic [31:0] DRAM_BASE = 32'h4000_0000,
  localparam int         IW        = $clog2(NSRC),
  localparam int         NLW       = (NSRC * LVL_W) / DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic            exc_req,
  input  logic            nmi_line,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            int_jump_taken,
  input  logic            cfg_we,
  input  logic [CW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            take_evt,
  output logic [1:0]      evt_kind,
  output logic [DW-1:0]   evt_target,
  output logic [IW-1:0]   evt_id
);
  localparam logic [IW-1:0] NMI_ID = IW'(NMI_IDX);

  logic [NSRC-1:0]   pend_q, mask_q;
  logic [NLW*DW-1:0] lvl_q;
  logic              nmi_hit, irq_hit;
  logic [IW-1:0]     irq_idx, sel_idx, rd_idx;
  logic [DW-1:0]     sel_vec, rd_vec, exc_q;
  logic              take_nx, take_clr;
  ev_kind_t          kind_nx;
  logic [DW-1:0]     tgt_nx;
  logic [IW-1:0]     id_nx;

  assign sel_idx = nmi_hit ? NMI_ID : irq_idx;
  assign rd_idx  = IW'(cfg_addr - CW'(A_VEC0));

  sev_pend_bank #(.NSRC(NSRC), .LVL_W(LVL_W), .NMI_IDX(NMI_IDX), .CW(CW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_line(nmi_line),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .take_clr(take_clr), .take_idx(sel_idx),
    .pend_q(pend_q), .mask_q(mask_q), .lvl_q(lvl_q));

  sev_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .NMI_IDX(NMI_IDX)) u_arb (
    .pend(pend_q), .mask(mask_q), .lvl_flat(lvl_q),
    .nmi_hit(nmi_hit), .irq_hit(irq_hit), .irq_idx(irq_idx));

  sev_vec_file #(.NSRC(NSRC), .CW(CW), .DW(DW)) u_vec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sel_idx(sel_idx), .rd_idx(rd_idx), .sel_vec(sel_vec), .rd_vec(rd_vec), .exc_q(exc_q));

  // class ranking: reset any time, the rest only on a taken interruptible jump
  always_comb begin
    take_nx  = 1'b0;
    take_clr = 1'b0;
    kind_nx  = EV_RST;
    tgt_nx   = DW'(DRAM_BASE);
    id_nx    = '0;
    if (rst_req) begin
      take_nx = 1'b1;
    end else if (int_jump_taken) begin
      if (exc_req) begin
        take_nx = 1'b1;
        kind_nx = EV_EXC;
        tgt_nx  = exc_q;
      end else if (nmi_hit || irq_hit) begin
        take_nx  = 1'b1;
        take_clr = 1'b1;
        kind_nx  = nmi_hit ? EV_NMI : EV_INT;
        tgt_nx   = sel_vec;
        id_nx    = sel_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_evt   <= 1'b0;
      evt_kind   <= EV_RST;
      evt_target <= '0;
      evt_id     <= '0;
    end else begin
      take_evt   <= take_nx;
      evt_kind   <= kind_nx;
      evt_target <= tgt_nx;
      evt_id     <= id_nx;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CW'(A_PEND))      cfg_rdata = DW'(pend_q);
    else if (cfg_addr == CW'(A_MASK)) cfg_rdata = DW'(mask_q);
    else if (cfg_addr == CW'(A_EXCV)) cfg_rdata = exc_q;
    else if (cfg_addr >= CW'(A_VEC0)) cfg_rdata = rd_vec;
    else
      for (int w = 0; w < NLW; w++)
        if (cfg_addr == CW'(A_LVL0 + w)) cfg_rdata = lvl_q[w*DW +: DW];
  end

  p_reset_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (take_evt && evt_kind == EV_RST && evt_target == DW'(DRAM_BASE)));

  p_jump_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !int_jump_taken) |=> !take_evt);

  p_exc_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_jump_taken && exc_req && !rst_req) |=> (take_evt && evt_kind == EV_EXC));

  p_nmi_over_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_jump_taken && !exc_req && !rst_req && pend_q[NMI_IDX])
    |=> (take_evt && evt_kind == EV_NMI && evt_id == NMI_ID));
endmodule

// File: tb/sev_dispatch_tb_top.sv
`timescale 1ns/1ps
module sev_dispatch_tb_top;
  localparam int          N    = 32;
  localparam int          NMI  = 0;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n, rst_req, exc_req, nmi_line, int_jump_taken, cfg_we;
  logic [31:0] irq_lines, cfg_wdata, cfg_rdata, evt_target;
  logic [5:0]  cfg_addr;
  logic        take_evt;
  logic [1:0]  evt_kind;
  logic [4:0]  evt_id;

  always #2.5 clk = ~clk;

  sev_dispatch #(.NSRC(N), .LVL_W(4), .NMI_IDX(NMI), .CW(6), .DW(32), .DRAM_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .exc_req(exc_req), .nmi_line(nmi_line),
    .irq_lines(irq_lines), .int_jump_taken(int_jump_taken), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .take_evt(take_evt), .evt_kind(evt_kind), .evt_target(evt_target), .evt_id(evt_id));

  // reference state, written from the requirements
  logic [31:0] m_pend, m_mask, m_exc;
  logic [3:0]  m_lvl [N];
  logic [31:0] m_vec [N];
  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [5:0] a);
    logic [31:0] r = '0;
    if (a == 6'd1) r = m_pend;
    else if (a == 6'd3) r = m_mask;
    else if (a == 6'd8) r = m_exc;
    else if (a >= 6'd32) r = m_vec[a - 6'd32];
    else if (a >= 6'd4 && a <= 6'd7)
      for (int j = 0; j < 8; j++) r[4*j +: 4] = m_lvl[(int'(a) - 4) * 8 + j];
    return r;
  endfunction

  // upward scan, strict comparison: first index of the top level
  function automatic int ref_pick();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (i != NMI && m_pend[i] && m_mask[i] && (b < 0 || m_lvl[i] > m_lvl[b])) b = i;
    return b;
  endfunction

  task automatic cyc(input logic rr, input logic ex, input logic nm, input logic jp,
                     input logic [31:0] ln, input logic we, input logic [5:0] ad,
                     input logic [31:0] wd);
    logic        e_take;
    logic [1:0]  e_kind;
    logic [31:0] e_tgt, setm, clrm;
    int          e_id, p;
    string       tg;
    @(negedge clk);
    rst_req = rr; exc_req = ex; nmi_line = nm; int_jump_taken = jp;
    irq_lines = ln; cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
    #1;
    if (!we) begin
      tg = (ad == 6'd1) ? "R5 pend" : (ad == 6'd3) ? "R7 mask" : (ad == 6'd8) ? "R4 excv" :
           (ad >= 6'd32) ? "R9 vec" : "R8 lvl";
      chk(cfg_rdata === ref_read(ad), tg, cfg_rdata, ref_read(ad));
    end
    e_take = 1'b0; e_kind = 2'd0; e_tgt = BASE; e_id = 0;
    p = ref_pick();
    if (rr) e_take = 1'b1;
    else if (jp) begin
      if (ex)              begin e_take = 1'b1; e_kind = 2'd1; e_tgt = m_exc; end
      else if (m_pend[NMI]) begin e_take = 1'b1; e_kind = 2'd2; e_id = NMI; e_tgt = m_vec[NMI]; end
      else if (p >= 0)     begin e_take = 1'b1; e_kind = 2'd3; e_id = p;   e_tgt = m_vec[p]; end
    end
    @(posedge clk);
    #1;
    tg = !e_take ? "R2 no-take" : (e_kind == 2'd0) ? "R1 reset" : (e_kind == 2'd1) ? "R4 exc" :
         (e_kind == 2'd2) ? "R7 nmi" : "R9 irq";
    chk(take_evt === e_take, tg, {31'd0, take_evt}, {31'd0, e_take});
    if (e_take) begin
      chk(evt_kind === e_kind, "R3 class", {30'd0, evt_kind}, {30'd0, e_kind});
      chk(evt_target === e_tgt, tg, evt_target, e_tgt);
      chk(evt_id === 5'(e_id), "R8 R9 id", {27'd0, evt_id}, 32'(e_id));
    end
    // model update: set wins over clear (R6), taken source cleared (R10)
    setm = ln | ((we && ad == 6'd0) ? wd : '0) | (nm ? (32'd1 << NMI) : '0);
    clrm = ((we && ad == 6'd2) ? wd : '0) |
           ((e_take && e_kind >= 2'd2) ? (32'd1 << e_id) : '0);
    m_pend = (m_pend & ~clrm) | setm;
    if (we) begin
      if (ad == 6'd3) m_mask = wd;
      if (ad == 6'd8) m_exc = wd;
      if (ad >= 6'd32) m_vec[ad - 6'd32] = wd;
      if (ad >= 6'd4 && ad <= 6'd7)
        for (int j = 0; j < 8; j++) m_lvl[(int'(ad) - 4) * 8 + j] = wd[4*j +: 4];
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 0, '0, 1, a, d);
  endtask
  task automatic rd(input logic [5:0] a);
    cyc(0, 0, 0, 0, '0, 0, a, '0);
  endtask
  task automatic jump(input logic ex);
    cyc(0, ex, 0, 1, '0, 0, 6'd1, '0);
  endtask

  task automatic run();
    logic [5:0] a;
    m_pend = '0; m_mask = '0; m_exc = '0;
    for (int i = 0; i < N; i++) begin m_lvl[i] = '0; m_vec[i] = '0; end
    rst_n = 1'b0; rst_req = 0; exc_req = 0; nmi_line = 0; int_jump_taken = 0;
    irq_lines = '0; cfg_we = 0; cfg_addr = 6'd1; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(take_evt === 1'b0, "R11 reset strobe", {31'd0, take_evt}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R11: registers read zero after reset
    rd(6'd1); rd(6'd3); rd(6'd8); rd(6'd4); rd(6'd40);
    // program vectors, levels and exception vector
    for (int i = 0; i < N; i++) wr(6'(32 + i), 32'h1000_0000 + 32'(i) * 32'h40);
    wr(6'd8, 32'h0000_0C00);
    // R2: pending but no jump, nothing taken
    wr(6'd3, 32'hFFFF_FFFE);
    wr(6'd0, 32'h0000_0104);
    rd(6'd1);
    rd(6'd1);
    // R6: zero clear keeps bits, then clear only bit 2
    wr(6'd2, 32'h0);
    rd(6'd1);
    wr(6'd2, 32'h0000_0004);
    rd(6'd1);
    // R7: masked source not taken at a jump
    wr(6'd3, 32'h0);
    jump(0);
    // R7: non-maskable bypasses the mask
    cyc(0, 0, 1, 0, '0, 0, 6'd1, '0);
    jump(0);
    rd(6'd1);
    // R8: equal levels, lower index wins; then a higher level wins
    wr(6'd3, 32'hFFFF_FFFE);
    wr(6'd4, 32'h0030_3000);
    wr(6'd5, 32'h0000_0070);
    wr(6'd0, 32'h0000_0228);
    jump(0);
    jump(0);
    jump(0);
    jump(0);
    // R10: pending empty after takes
    rd(6'd1);
    // R3: exception beats pending interrupts; reset beats everything
    wr(6'd0, 32'h0000_0021);
    jump(1);
    cyc(1, 1, 0, 1, '0, 0, 6'd1, '0);
    // R1: reset with no jump
    cyc(1, 0, 0, 0, '0, 0, 6'd1, '0);
    jump(0);
    jump(0);
    // R6: set and clear of one bit in the same cycle, set wins
    cyc(0, 0, 0, 0, 32'h0000_0800, 1, 6'd2, 32'h0000_0800);
    rd(6'd1);
    // constrained random mix
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ln, wd;
      logic        we;
      ln = (($urandom % 4) == 0) ? ($urandom & $urandom & $urandom & $urandom) : '0;
      we = ($urandom % 5) == 0;
      wd = $urandom;
      case ($urandom % 6)
        0: a = 6'd0;
        1: a = 6'd2;
        2: a = 6'd3;
        3: a = 6'(4 + $urandom % 4);
        4: a = 6'd8;
        default: a = 6'(32 + $urandom % 32);
      endcase
      if (!we && ($urandom % 2) == 0) a = 6'd1;
      if (we && a == 6'd0) wd = wd & $urandom & $urandom;
      cyc(($urandom % 50) == 0, ($urandom % 12) == 0, ($urandom % 20) == 0,
          ($urandom % 3) == 0, ln, we, a, wd);
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=hang exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule